// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Load/Store Processor Core

This block is a compact processor core for a word-addressed machine with 16-bit words, a 16-bit address space and eight general registers. Each instruction walks through a fixed chain of phases: the word at the program counter is fetched and the counter advances, the word is decoded, an effective address is formed and registered, operands are read from memory where the instruction needs them, and the result is written back to a register or to memory. Condition flags (negative, zero, positive) follow every register write and steer conditional branches.

The core has one synchronous memory port. It presents an address, write data and a write strobe, and the read word comes back on the clock edge after the address. Operate instructions cover add, bitwise and, and bitwise invert. Memory operands are reached by PC-relative, indirect (pointer read first) and base-plus-offset addressing. An address-only load, a flag-tested branch and a register jump complete the set. An unused opcode stops the core for good.

Top module: `mc16_core`

## Requirements
- R1: While reset is held and after its release, the program counter is x3000, all eight registers are zero, the flags read zero (Z set), `halted` is low, and the first memory access reads address x3000.
- R2: Every instruction begins with a read of the word at PC, and PC then advances by one modulo 2^16; read data arrives on the clock edge after the address.
- R3: Opcode 0001 adds, 0101 ands and 1001 inverts. The destination is IR[11:9] and the first source is IR[8:6]. For add and and, IR[5]=0 takes the second source from the register in IR[2:0], and IR[5]=1 takes IR[4:0] sign-extended.
- R4: Every register write sets exactly one flag, chosen by the written value: N if bit 15 is set, Z if the value is zero, P otherwise. Stores, branches and jumps leave the flags unchanged.
- R5: Opcode 0010 loads from the incremented PC plus IR[8:0] sign-extended. Opcode 0110 loads from the register in IR[8:6] plus IR[5:0] sign-extended. Opcode 1110 writes that PC-relative address itself into IR[11:9] and makes no data access. All sums wrap modulo 2^16.
- R6: Opcodes 1010 (load) and 1011 (store) first read the word at the PC-relative address and then use that word as the address of the data access.
- R7: Opcodes 0011 (PC-relative), 0111 (base plus offset) and 1011 write the register named by IR[11:9] to memory, raising the write strobe for exactly one cycle.
- R8: Opcode 0000 loads PC with the PC-relative address when IR[11:9], read as N,Z,P from bit 11 down, shares a set bit with the flags. Otherwise execution falls through, and a mask of 000 never branches.
- R9: Opcode 1100 loads PC with the register named by IR[8:6].
- R10: Opcodes 0100, 1000, 1101 and 1111 raise `halted` in the cycle after their decode. `halted` then stays high, and the core neither writes memory nor fetches again.
- R11: An instruction takes 4 cycles for operate, address-only load, branch, jump and the PC-relative or base-plus-offset stores. Direct and base-plus-offset loads take 5 cycles, the indirect store 6 and the indirect load 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Word address of the memory access |
| mem_wdata | output | 16 | Data written when `mem_we` is high |
| mem_rdata | input | 16 | Word read from the address of the previous cycle |
| mem_we | output | 1 | Write strobe for the current address |
| halted | output | 1 | High once an unused opcode has been decoded |

## Verification
A wrong register, flag or counter value inside the core stays hidden until it reaches the memory port. A corrupted PC shows up one cycle later as a wrong fetch address, a flag error as a branch taken or missed at the next conditional, and a bad register as wrong store data or a wrong load or jump address. The bench therefore predicts every cycle's write strobe, halt state and access address from an instruction-level model, so a fault is caught at the first cycle where it reaches the port. A miscounted phase sequence is caught as a shifted fetch.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
package mc16_pkg;
  localparam int XLEN   = 16;
  localparam int NREG   = 8;
  localparam int RIDX   = $clog2(NREG);
  localparam int OPW    = 4;
  localparam int FLAGW  = 3;

  typedef enum logic [OPW-1:0] {
    OP_BR   = 4'b0000, OP_ADD  = 4'b0001, OP_LD   = 4'b0010, OP_ST   = 4'b0011,
    OP_RSV4 = 4'b0100, OP_AND  = 4'b0101, OP_LDR  = 4'b0110, OP_STR  = 4'b0111,
    OP_RSV8 = 4'b1000, OP_NOT  = 4'b1001, OP_LDI  = 4'b1010, OP_STI  = 4'b1011,
    OP_JMP  = 4'b1100, OP_RSVD = 4'b1101, OP_LEA  = 4'b1110, OP_RSVF = 4'b1111
  } opcode_e;

  typedef enum logic [3:0] {
    PH_FETCH, PH_DECODE, PH_EVAL, PH_IND, PH_INDW,
    PH_OPND, PH_EXEC, PH_STORE, PH_HALT
  } phase_e;

  // Sign-extend the low w bits of raw to the full word.
  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] raw, input int w);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++)
      r[i] = (i < w) ? raw[i] : raw[w-1];
    return r;
  endfunction

  // Flags for a written value: {neg, zero, pos}.
  function automatic logic [FLAGW-1:0] flags_of(input logic [XLEN-1:0] v);
    logic neg, zer;
    neg = v[XLEN-1];
    zer = (v == '0);
    return {neg, zer, !neg && !zer};
  endfunction

  function automatic logic op_known(input logic [OPW-1:0] op);
    case (opcode_e'(op))
      OP_RSV4, OP_RSV8, OP_RSVD, OP_RSVF: return 1'b0;
      default:                            return 1'b1;
    endcase
  endfunction

  function automatic logic op_writes_reg(input opcode_e op);
    case (op)
      OP_ADD, OP_AND, OP_NOT, OP_LD, OP_LDR, OP_LDI, OP_LEA: return 1'b1;
      default:                                               return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_load(input opcode_e op);
    return (op == OP_LD) || (op == OP_LDR) || (op == OP_LDI);
  endfunction

  function automatic logic op_is_store(input opcode_e op);
    return (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
  endfunction
endpackage

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
module mc16_regfile
  import mc16_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = XLEN,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (wa == AW'(g)))
        regs[g] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
endmodule

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  opcode_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_AND:  y = a & b;
      OP_NOT:  y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/mc16_agen.sv
`timescale 1ns/1ps
module mc16_agen
  import mc16_pkg::*;
#(
  parameter int W     = XLEN,
  parameter int PCOFW = 9,
  parameter int BOFW  = 6
) (
  input  opcode_e      op,
  input  logic [W-1:0] ir,
  input  logic [W-1:0] pc_next,
  input  logic [W-1:0] base,
  output logic [W-1:0] ea
);
  logic          use_base;
  logic [W-1:0]  off;

  assign use_base = (op == OP_LDR) || (op == OP_STR);
  assign off      = use_base ? sext(ir, BOFW) : sext(ir, PCOFW);
  assign ea       = (use_base ? base : pc_next) + off;
endmodule

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
module mc16_core
  import mc16_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 16'h3000,
  parameter int              IMMW     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_we,
  output logic            halted
);
  phase_e           phase_q;
  logic [XLEN-1:0]  pc_q, ir_q, mar_q;
  logic [FLAGW-1:0] cc_q;
  opcode_e          op;

  logic [RIDX-1:0]  ra1, ra2, wa;
  logic [XLEN-1:0]  rd1, rd2, alu_b, alu_y, ea, rf_wdata;
  logic             ev_fetch, ev_rf_we, ev_br_taken, ev_jump;

  assign op = opcode_e'(ir_q[XLEN-1 -: OPW]);

  // register file addressing
  assign ra1 = ir_q[8:6];
  assign ra2 = op_is_store(op) ? ir_q[11:9] : ir_q[2:0];
  assign wa  = ir_q[11:9];

  mc16_regfile #(.N(NREG), .W(XLEN)) u_rf (
    .clk (clk), .rst_n (rst_n),
    .ra1 (ra1), .rd1 (rd1),
    .ra2 (ra2), .rd2 (rd2),
    .we  (ev_rf_we), .wa (wa), .wd (rf_wdata)
  );

  assign alu_b = ir_q[5] ? sext(ir_q, IMMW) : rd2;

  mc16_alu #(.W(XLEN)) u_alu (
    .op (op), .a (rd1), .b (alu_b), .y (alu_y)
  );

  mc16_agen #(.W(XLEN)) u_agen (
    .op (op), .ir (ir_q), .pc_next (pc_q), .base (rd1), .ea (ea)
  );

  // named events for checking
  assign ev_fetch    = (phase_q == PH_FETCH);
  assign ev_rf_we    = (phase_q == PH_EXEC) && op_writes_reg(op);
  assign ev_br_taken = (phase_q == PH_EXEC) && (op == OP_BR) && |(ir_q[11:9] & cc_q);
  assign ev_jump     = (phase_q == PH_EXEC) && (op == OP_JMP);

  always_comb begin
    if (op_is_load(op))  rf_wdata = mem_rdata;
    else if (op == OP_LEA) rf_wdata = mar_q;
    else                 rf_wdata = alu_y;
  end

  // memory port
  always_comb begin
    case (phase_q)
      PH_IND, PH_OPND, PH_STORE: mem_addr = mar_q;
      default:                   mem_addr = pc_q;
    endcase
  end
  assign mem_we    = (phase_q == PH_STORE);
  assign mem_wdata = rd2;
  assign halted    = (phase_q == PH_HALT);

  // phase sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FETCH;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      mar_q   <= '0;
      cc_q    <= 3'b010;
    end else begin
      case (phase_q)
        PH_FETCH: begin
          pc_q    <= pc_q + 1'b1;
          phase_q <= PH_DECODE;
        end
        PH_DECODE: begin
          ir_q    <= mem_rdata;
          phase_q <= op_known(mem_rdata[XLEN-1 -: OPW]) ? PH_EVAL : PH_HALT;
        end
        PH_EVAL: begin
          mar_q <= ea;
          case (op)
            OP_LD, OP_LDR:  phase_q <= PH_OPND;
            OP_LDI, OP_STI: phase_q <= PH_IND;
            OP_ST, OP_STR:  phase_q <= PH_STORE;
            default:        phase_q <= PH_EXEC;
          endcase
        end
        PH_IND:  phase_q <= PH_INDW;
        PH_INDW: begin
          mar_q   <= mem_rdata;
          phase_q <= (op == OP_STI) ? PH_STORE : PH_OPND;
        end
        PH_OPND: phase_q <= PH_EXEC;
        PH_EXEC: begin
          if (ev_rf_we)    cc_q <= flags_of(rf_wdata);
          if (ev_br_taken) pc_q <= mar_q;
          if (ev_jump)     pc_q <= rd1;
          phase_q <= PH_FETCH;
        end
        PH_STORE: phase_q <= PH_FETCH;
        default:  phase_q <= PH_HALT;
      endcase
    end
  end
endmodule

// File: rtl/mc16_core_chk.sv
`timescale 1ns/1ps
module mc16_core_chk
  import mc16_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             halted,
  input logic             mem_we,
  input logic             ev_fetch,
  input logic             ev_rf_we,
  input logic [XLEN-1:0]  pc_q,
  input logic [FLAGW-1:0] cc_q,
  input logic [XLEN-1:0]  rf_wdata
);
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> pc_q == $past(pc_q) + 16'd1); // R2
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_q) == 1); // R4
  AST_FLAG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rf_we |=> cc_q[2] == $past(rf_wdata[XLEN-1])); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rf_we |=> $stable(cc_q)); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R7
  AST_WE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> ev_fetch); // R11
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we && !ev_fetch); // R10
endmodule

bind mc16_core mc16_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .halted   (halted),
  .mem_we   (mem_we),
  .ev_fetch (ev_fetch),
  .ev_rf_we (ev_rf_we),
  .pc_q     (pc_q),
  .cc_q     (cc_q),
  .rf_wdata (rf_wdata)
);

// File: tb/mc16_core_test.sv
`timescale 1ns/1ps
module mc16_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, halted;

  always #2.5 clk = ~clk;

  mc16_core uut (
    .clk (clk), .rst_n (rst_n),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .mem_we (mem_we), .halted (halted)
  );

  // bench memory, 4K words aliased over the address space
  logic [15:0] ram [0:4095];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[11:0]];
  end

  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  // behavioural model
  logic [15:0] mm [0:4095];
  logic [15:0] mr [8];
  logic [15:0] mpc;
  logic [2:0]  mcc;
  bit          mhalt;

  bit          q_chk[$], q_we[$], q_halt[$];
  logic [15:0] q_addr[$], q_wd[$];
  string       q_req[$];

  task automatic push(bit c, logic [15:0] a, bit we, logic [15:0] wd, bit h, string r);
    q_chk.push_back(c); q_addr.push_back(a); q_we.push_back(we);
    q_wd.push_back(wd); q_halt.push_back(h); q_req.push_back(r);
  endtask

  task automatic put(logic [15:0] a, logic [15:0] w);
    ram[a[11:0]] = w; mm[a[11:0]] = w;
  endtask

  task automatic wr(logic [2:0] d, logic [15:0] v);
    mr[d] = v;
    if (v[15]) mcc = 3'b100; else if (v == 0) mcc = 3'b010; else mcc = 3'b001;
  endtask

  task automatic model_step();
    logic [15:0] ir, pcr, bor, p, b, v;
    int op;
    if (mhalt) begin push(0, 0, 0, 0, 1, "R10"); return; end
    ir = mm[mpc[11:0]];
    push(1, mpc, 0, 0, 0, "R2");
    mpc = mpc + 16'd1;
    push(0, 0, 0, 0, 0, "R11");
    op = int'(ir[15:12]);
    if (op == 4 || op == 8 || op == 13 || op == 15) begin mhalt = 1; return; end
    push(0, 0, 0, 0, 0, "R11");
    pcr = mpc + {{7{ir[8]}}, ir[8:0]};
    bor = mr[ir[8:6]] + {{10{ir[5]}}, ir[5:0]};
    case (op)
      1, 5: begin
        b = ir[5] ? {{11{ir[4]}}, ir[4:0]} : mr[ir[2:0]];
        v = (op == 1) ? mr[ir[8:6]] + b : mr[ir[8:6]] & b;
        wr(ir[11:9], v); push(0, 0, 0, 0, 0, "R3");
      end
      9: begin wr(ir[11:9], ~mr[ir[8:6]]); push(0, 0, 0, 0, 0, "R3"); end
      2, 6: begin
        p = (op == 2) ? pcr : bor;
        push(1, p, 0, 0, 0, "R5"); push(0, 0, 0, 0, 0, "R5");
        wr(ir[11:9], mm[p[11:0]]);
      end
      10: begin
        p = mm[pcr[11:0]];
        push(1, pcr, 0, 0, 0, "R6"); push(0, 0, 0, 0, 0, "R6");
        push(1, p, 0, 0, 0, "R6"); push(0, 0, 0, 0, 0, "R6");
        wr(ir[11:9], mm[p[11:0]]);
      end
      3, 7: begin
        p = (op == 3) ? pcr : bor;
        push(1, p, 1, mr[ir[11:9]], 0, "R7");
        mm[p[11:0]] = mr[ir[11:9]];
      end
      11: begin
        p = mm[pcr[11:0]];
        push(1, pcr, 0, 0, 0, "R6"); push(0, 0, 0, 0, 0, "R6");
        push(1, p, 1, mr[ir[11:9]], 0, "R6");
        mm[p[11:0]] = mr[ir[11:9]];
      end
      14: begin wr(ir[11:9], pcr); push(0, 0, 0, 0, 0, "R5"); end
      0: begin
        if ((ir[11:9] & mcc) != 0) mpc = pcr;
        push(0, 0, 0, 0, 0, "R8");
      end
      default: begin mpc = mr[ir[8:6]]; push(0, 0, 0, 0, 0, "R9"); end
    endcase
  endtask

  task automatic check_eq(string req, string what, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 4096; i++) begin ram[i] = 16'h0000; mm[i] = 16'h0000; end
    put(16'h3000, 16'h0401); // BRz +1 : flags are Z after reset (R1, R8)
    put(16'h3001, 16'hD000); // unused opcode, skipped
    put(16'h3002, 16'hE2FD); // LEA R1 -> x3100
    put(16'h3003, 16'h56E0); // AND R3,R3,#0
    put(16'h3004, 16'h14E4); // ADD R2,R3,#4
    put(16'h3005, 16'h0405); // BRz x300B
    put(16'h3006, 16'h6840); // LDR R4,R1,#0
    put(16'h3007, 16'h16C4); // ADD R3,R3,R4
    put(16'h3008, 16'h1261); // ADD R1,R1,#1
    put(16'h3009, 16'h14BF); // ADD R2,R2,#-1
    put(16'h300A, 16'h0FFA); // BRnzp x3005
    put(16'h300B, 16'h3674); // ST R3 -> x3080
    put(16'h300C, 16'h9AFF); // NOT R5,R3
    put(16'h300D, 16'hAC02); // LDI R6 via x3010
    put(16'h300E, 16'hBA02); // STI R5 via x3011
    put(16'h300F, 16'h0E02); // BRnzp x3012
    put(16'h3010, 16'h3104); // pointer
    put(16'h3011, 16'h3081); // pointer
    put(16'h3012, 16'hEE05); // LEA R7 -> x3018
    put(16'h3013, 16'h7C7E); // STR R6,R1,#-2
    put(16'h3014, 16'h20ED); // LD R0 <- x3102
    put(16'h3015, 16'h5006); // AND R0,R0,R6
    put(16'h3016, 16'hC1C0); // JMP R7
    put(16'h3017, 16'hF025); // unused opcode, skipped
    put(16'h3018, 16'h7041); // STR R0,R1,#1
    put(16'h3019, 16'h1545); // ADD R2,R5,R5
    put(16'h301A, 16'h0801); // BRn +1
    put(16'h301B, 16'hD000); // skipped
    put(16'h301C, 16'h8000); // unused opcode: halt
    put(16'h3100, 16'h0005);
    put(16'h3101, 16'h0007);
    put(16'h3102, 16'hFFFF);
    put(16'h3103, 16'h0064);
    put(16'h3104, 16'h1234);
  endtask

  initial begin
    int halts;
    load_program();
    for (int i = 0; i < 8; i++) mr[i] = 16'h0000;
    mpc = 16'h3000; mcc = 3'b010; mhalt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check_eq("R1", "halted in reset", {15'd0, halted}, 16'd0);
    check_eq("R1", "mem_we in reset", {15'd0, mem_we}, 16'd0);
    check_eq("R1", "first address", mem_addr, 16'h3000);
    rst_n = 1'b1;
    halts = 0;
    for (int cyc = 0; cyc < 5000 && halts < 6; cyc++) begin
      bit c, w, h; logic [15:0] a, d; string r;
      if (q_chk.size() == 0) model_step();
      c = q_chk.pop_front(); a = q_addr.pop_front(); w = q_we.pop_front();
      d = q_wd.pop_front(); h = q_halt.pop_front(); r = q_req.pop_front();
      nvec++;
      if (mem_we !== w || halted !== h || (c && mem_addr !== a) || (w && mem_wdata !== d)) begin
        nfail++;
        $display("FAIL %s cycle %0d: actual we=%b halt=%b addr=%h wd=%h expected we=%b halt=%b addr=%h wd=%h",
                 r, cyc, mem_we, halted, mem_addr, mem_wdata, w, h, a, d);
      end
      if (h) halts++;
      @(posedge clk); @(negedge clk);
    end
    // independent end-of-program results
    check_eq("R3", "sum of four words", ram[12'h080], 16'h006F);      // 5+7-1+100
    check_eq("R6", "inverted sum via pointer", ram[12'h081], 16'hFF90);
    check_eq("R7", "base-offset store of pointed word", ram[12'h102], 16'h1234);
    check_eq("R5", "load then and then store", ram[12'h105], 16'h1234);
    check_eq("R10", "halted at end", {15'd0, halted}, 16'd1);
    check_eq("R10", "no write after halt", {15'd0, mem_we}, 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule